// File: doc/BRIEF.md
# Offset-Driven PI Clock Servo with Lock Detection

This block disciplines a timing wallclock. Each measured clock offset (signed nanoseconds) arrives on a valid/ready stream. It is smoothed by a power-of-two-deep moving average, and the smoothed value drives a proportional-integral loop. The integral step is scaled by the sync message interval. Each accepted offset produces exactly one frequency correction in parts per billion on an output valid/ready stream. A lock flag with separate acquire and release thresholds tells the rest of the chip when the clock has settled.

Back-pressure works as follows. The block holds one sample at a time. `in_ready` is low while a sample is in flight, and also while a finished correction waits for `out_ready`. A correction stays on `out_ppb` with `out_valid` high until the consumer takes it. Gains are build-time constants, or, with `RUNTIME_GAINS`=1, plain register inputs loaded by a write strobe. A synchronous clear restarts the loop without a full reset.

Top module: `ptp_pi_servo`

## Requirements
- R1: An offset is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while a sample is being processed and while `out_valid` is high with `out_ready` low.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_ppb` does not change.
- R3: `out_valid` rises on the second rising edge after the accepting edge, not on the first, and each accepted offset gives exactly one correction.
- R4: The smoothed offset is floor(sum of the last 2^`AVG_LOG2` offsets / 2^`AVG_LOG2`). Slots not yet filled since reset or clear count as zero. With kp=256 and ki=0 the correction is exactly the negated smoothed offset.
- R5: The proportional term is floor(avg·kp/256). The integrator adds floor(avg·ki·2^li/256) per sample. The correction is −(proportional + new integrator). Gains are unsigned 16-bit values in units of 1/256.
- R6: `log_interval` is a signed 4-bit value li, captured with the offset. Values outside −4..+4 are used as −4 or +4.
- R7: The integrator is clamped to ±`INT_LIM` (default 400000) after each step.
- R8: The correction is saturated to ±`OUT_LIM` (default 500000 PPB).
- R9: `locked` is set when a smoothed offset has magnitude strictly below `LOCK_NS` (default 500).
- R10: `locked` clears only when a smoothed magnitude is strictly above `UNLOCK_NS` (default 5000). Between the two thresholds it keeps its value, and it changes only together with a new correction or a clear.
- R11: After reset or a one-cycle `clr`, the averager and integrator are empty, `locked` and `out_valid` are low, and `in_ready` is high.
- R12: With `RUNTIME_GAINS`=1, a cycle with `cfg_we` high loads `cfg_kp` and `cfg_ki`. The new gains apply to later samples. Reset loads kp=128 and ki=32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of averager, integrator, lock and pending output |
| in_valid | input | 1 | Offset sample present |
| in_ready | output | 1 | Block can take an offset |
| in_ofs | input | OFS_W | Signed offset in ns |
| log_interval | input | 4 | Signed log2 of the sync interval, captured with the offset |
| out_valid | output | 1 | Correction present |
| out_ready | input | 1 | Consumer takes the correction |
| out_ppb | output | PPB_W | Signed frequency correction in PPB |
| locked | output | 1 | Lock indicator with hysteresis |
| cfg_we | input | 1 | Gain write strobe (runtime-gain build only) |
| cfg_kp | input | GAIN_W | Proportional gain, /256 |
| cfg_ki | input | GAIN_W | Integral gain, /256 |

## Verification
The assertions assume that a sample offered on `in_valid` stays offered until it is taken. They also assume that `clr` is a lone pulse, not a level held across a handshake. The latency property is switched off during a clear, because a clear drops the sample in flight. The directed tasks drive every input on the falling edge and hold `in_valid` until `in_ready` is seen. They pulse `clr` and `cfg_we` for exactly one cycle, and only when no sample is in flight. Offsets stay within ±4,000,000 ns, so the averager sum and the gain products have headroom.

// File: rtl/ptp_servo_pkg.sv
package ptp_servo_pkg;
  localparam int GAIN_FRAC = 8;
  localparam int LI_MAX    = 4;

  function automatic logic signed [3:0] clamp_li(input logic signed [3:0] li);
    if (li > 4'sd4)       return 4'sd4;
    else if (li < -4'sd4) return -4'sd4;
    else                  return li;
  endfunction
endpackage

// File: rtl/ptp_ofs_avg.sv
module ptp_ofs_avg #(
  parameter int W = 32,
  parameter int L = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                fire,
  input  logic signed [W-1:0] ofs,
  output logic                avg_valid,
  output logic signed [W-1:0] avg
);
  localparam int D  = 1 << L;
  localparam int SW = W + L;

  logic signed [W-1:0]  ring [D];
  logic        [L-1:0]  wp;
  logic signed [SW-1:0] sum, sum_nx;

  assign sum_nx = sum + SW'(ofs) - SW'(ring[wp]);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int i = 0; i < D; i++) ring[i] <= '0;
      wp        <= '0;
      sum       <= '0;
      avg       <= '0;
      avg_valid <= 1'b0;
    end else begin
      avg_valid <= fire;
      if (fire) begin
        ring[wp] <= ofs;
        wp       <= wp + 1'b1;
        sum      <= sum_nx;
        avg      <= W'(sum_nx >>> L);
      end
    end
  end
endmodule

// File: rtl/ptp_lock_det.sv
module ptp_lock_det #(
  parameter int W         = 32,
  parameter int LOCK_NS   = 500,
  parameter int UNLOCK_NS = 5000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                upd,
  input  logic signed [W-1:0] avg,
  output logic                locked
);
  logic [W:0] mag;
  assign mag = avg[W-1] ? ((W+1)'(0) - (W+1)'(avg)) : (W+1)'(avg);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)                          locked <= 1'b0;
    else if (upd && mag < (W+1)'(LOCK_NS))      locked <= 1'b1;
    else if (upd && mag > (W+1)'(UNLOCK_NS))    locked <= 1'b0;
  end
endmodule

// File: rtl/ptp_pi_core.sv
module ptp_pi_core
  import ptp_servo_pkg::*;
#(
  parameter int W       = 32,
  parameter int GW      = 16,
  parameter int PPBW    = 32,
  parameter int INT_LIM = 400000,
  parameter int OUT_LIM = 500000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   upd,
  input  logic signed [W-1:0]    avg,
  input  logic        [GW-1:0]   kp,
  input  logic        [GW-1:0]   ki,
  input  logic signed [3:0]      li,
  output logic signed [PPBW-1:0] ppb
);
  localparam int PW = W + GW + 6;
  localparam int IW = W + 8;
  localparam logic signed [PW-1:0] ILIM = PW'(INT_LIM);
  localparam logic signed [PW-1:0] OLIM = PW'(OUT_LIM);

  logic signed [IW-1:0] integ;
  logic signed [PW-1:0] pterm, iprod, istep, isum, inext, tot;
  logic signed [3:0]    lic;
  logic        [4:0]    ishift;

  assign lic    = clamp_li(li);
  assign ishift = 5'(GAIN_FRAC + LI_MAX) - 5'(lic);
  assign pterm  = (PW'(avg) * $signed({1'b0, kp})) >>> GAIN_FRAC;
  assign iprod  = PW'(avg) * $signed({1'b0, ki});
  assign istep  = (iprod <<< LI_MAX) >>> ishift;
  assign isum   = PW'(integ) + istep;

  always_comb begin
    if (isum > ILIM)       inext = ILIM;
    else if (isum < -ILIM) inext = -ILIM;
    else                   inext = isum;
    tot = -(pterm + inext);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      integ <= '0;
      ppb   <= '0;
    end else if (upd) begin
      integ <= IW'(inext);
      if (tot > OLIM)       ppb <= PPBW'(OLIM);
      else if (tot < -OLIM) ppb <= PPBW'(-OLIM);
      else                  ppb <= PPBW'(tot);
    end
  end
endmodule

// File: rtl/ptp_pi_servo.sv
module ptp_pi_servo #(
  parameter int OFS_W         = 32,
  parameter int AVG_LOG2      = 3,
  parameter int GAIN_W        = 16,
  parameter int PPB_W         = 32,
  parameter int INT_LIM       = 400000,
  parameter int OUT_LIM       = 500000,
  parameter int LOCK_NS       = 500,
  parameter int UNLOCK_NS     = 5000,
  parameter bit RUNTIME_GAINS = 1'b0,
  parameter int KP_DEF        = 128,
  parameter int KI_DEF        = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [OFS_W-1:0] in_ofs,
  input  logic signed [3:0]       log_interval,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [PPB_W-1:0] out_ppb,
  output logic                    locked,
  input  logic                    cfg_we,
  input  logic        [GAIN_W-1:0] cfg_kp,
  input  logic        [GAIN_W-1:0] cfg_ki
);
  logic                    fire, avg_v;
  logic signed [OFS_W-1:0] avg;
  logic signed [3:0]       li_q;
  logic [GAIN_W-1:0]       kp, ki;

  assign in_ready = !avg_v && (!out_valid || out_ready);
  assign fire     = in_valid && in_ready;

  generate
    if (RUNTIME_GAINS) begin : g_rt
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          kp <= GAIN_W'(KP_DEF);
          ki <= GAIN_W'(KI_DEF);
        end else if (cfg_we) begin
          kp <= cfg_kp;
          ki <= cfg_ki;
        end
      end
    end else begin : g_fix
      logic cfg_unused;
      assign cfg_unused = ^{cfg_we, cfg_kp, cfg_ki};
      assign kp = GAIN_W'(KP_DEF);
      assign ki = GAIN_W'(KI_DEF);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      li_q      <= '0;
      out_valid <= 1'b0;
    end else begin
      if (fire) li_q <= log_interval;
      if (avg_v)          out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  ptp_ofs_avg #(.W(OFS_W), .L(AVG_LOG2)) u_avg (
    .clk(clk), .rst_n(rst_n), .clr(clr), .fire(fire), .ofs(in_ofs),
    .avg_valid(avg_v), .avg(avg)
  );

  ptp_pi_core #(
    .W(OFS_W), .GW(GAIN_W), .PPBW(PPB_W), .INT_LIM(INT_LIM), .OUT_LIM(OUT_LIM)
  ) u_pi (
    .clk(clk), .rst_n(rst_n), .clr(clr), .upd(avg_v), .avg(avg),
    .kp(kp), .ki(ki), .li(li_q), .ppb(out_ppb)
  );

  ptp_lock_det #(.W(OFS_W), .LOCK_NS(LOCK_NS), .UNLOCK_NS(UNLOCK_NS)) u_lock (
    .clk(clk), .rst_n(rst_n), .clr(clr), .upd(avg_v), .avg(avg), .locked(locked)
  );
endmodule

// File: rtl/ptp_pi_servo_chk.sv
module ptp_pi_servo_chk #(
  parameter int PPB_W   = 32,
  parameter int OUT_LIM = 500000
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clr,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [PPB_W-1:0] out_ppb,
  input logic                    locked
);
  p_stall_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ppb)));

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (in_valid && in_ready) |=> (!out_valid ##1 out_valid));

  p_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_ppb <= PPB_W'(OUT_LIM) && out_ppb >= -PPB_W'(OUT_LIM)));

  p_lock_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> out_valid);

  p_lock_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> (out_valid || $past(clr)));
endmodule

bind ptp_pi_servo ptp_pi_servo_chk #(.PPB_W(PPB_W), .OUT_LIM(OUT_LIM)) u_chk (.*);

// File: tb/ptp_pi_servo_bench.sv
module ptp_pi_servo_bench;
  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1, cfg_we = 1'b0;
  logic in_ready, out_valid, locked;
  logic signed [31:0] in_ofs = '0, out_ppb;
  logic signed [3:0]  log_interval = '0;
  logic [15:0] cfg_kp = 16'd128, cfg_ki = 16'd32;

  always #5 clk = ~clk;

  ptp_pi_servo #(.RUNTIME_GAINS(1'b1)) u_ptp_pi_servo (.*);

  int total = 0, bad = 0;
  longint m_ring [8];
  int     m_wp;
  longint m_sum, m_int, m_kp = 128, m_ki = 32;
  bit     m_lock;

  task automatic check(input string r, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  function automatic void model_clear();
    for (int i = 0; i < 8; i++) m_ring[i] = 0;
    m_wp = 0; m_sum = 0; m_int = 0; m_lock = 0;
  endfunction

  task automatic send(input longint x, input int li, input string tag);
    longint avg, p, pr, st, o, mag;
    int lic;
    m_sum = m_sum + x - m_ring[m_wp];
    m_ring[m_wp] = x;
    m_wp = (m_wp + 1) % 8;
    avg = m_sum >>> 3;
    p = (avg * m_kp) >>> 8;
    lic = (li > 4) ? 4 : (li < -4) ? -4 : li;
    pr = avg * m_ki;
    st = (lic >= 0) ? ((pr <<< lic) >>> 8) : (pr >>> (8 - lic));
    m_int = m_int + st;
    if (m_int > 400000) m_int = 400000;
    if (m_int < -400000) m_int = -400000;
    o = -(p + m_int);
    if (o > 500000) o = 500000;
    if (o < -500000) o = -500000;
    mag = (avg < 0) ? -avg : avg;
    if (mag < 500) m_lock = 1;
    else if (mag > 5000) m_lock = 0;

    @(negedge clk);
    in_valid = 1'b1; in_ofs = 32'(x); log_interval = 4'(li);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 no output after first edge", longint'(out_valid), 0);
    @(negedge clk);
    check("R3 output after second edge", longint'(out_valid), 1);
    check({tag, " correction"}, longint'(out_ppb), o);
    check("R9/R10 lock flag", longint'(locked), longint'(m_lock));
  endtask

  task automatic set_gains(input int kp, input int ki);
    @(negedge clk);
    cfg_kp = 16'(kp); cfg_ki = 16'(ki); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    m_kp = kp; m_ki = ki;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    model_clear();
  endtask

  task automatic t_reset();
    check("R11 reset in_ready", longint'(in_ready), 1);
    check("R11 reset out_valid", longint'(out_valid), 0);
    check("R11 reset locked", longint'(locked), 0);
  endtask

  task automatic t_default_pi();
    send(800, 0, "R5");
    send(-1200, 0, "R5");
    send(3000, 1, "R5");
    send(-7, 0, "R5");
  endtask

  task automatic t_average();
    pulse_clr();
    set_gains(256, 0);
    send(800, 0, "R4");
    check("R4 first sample over empty slots", longint'(out_ppb), -100);
    for (int i = 0; i < 9; i++) send(1000 + i * 37, 0, "R4");
    send(-13, 0, "R4");
    set_gains(128, 32);
  endtask

  task automatic t_interval();
    pulse_clr();
    send(4000, 2, "R6");
    send(4000, -3, "R6");
    send(4000, 7, "R6 clamp high");
    send(4000, -8, "R6 clamp low");
  endtask

  task automatic t_integ_clamp();
    pulse_clr();
    set_gains(0, 256);
    for (int i = 0; i < 12; i++) send(200000, 0, "R7");
    check("R7 integrator clamp", longint'(out_ppb), -400000);
    for (int i = 0; i < 4; i++) send(-100000, 0, "R7");
    set_gains(128, 32);
  endtask

  task automatic t_saturate();
    pulse_clr();
    set_gains(256, 0);
    for (int i = 0; i < 8; i++) send(4000000, 0, "R8");
    check("R8 positive offset saturates", longint'(out_ppb), -500000);
    for (int i = 0; i < 8; i++) send(-4000000, 0, "R8");
    check("R8 negative offset saturates", longint'(out_ppb), 500000);
    set_gains(128, 32);
  endtask

  task automatic t_lock();
    pulse_clr();
    for (int i = 0; i < 8; i++) send(8000, 0, "R9");
    check("R10 far offset unlocked", longint'(locked), 0);
    for (int i = 0; i < 8; i++) send(0, 0, "R9");
    check("R9 small offset locks", longint'(locked), 1);
    for (int i = 0; i < 8; i++) send(3000, 0, "R10");
    check("R10 mid band holds lock", longint'(locked), 1);
    for (int i = 0; i < 8; i++) send(8000, 0, "R10");
    check("R10 large offset unlocks", longint'(locked), 0);
  endtask

  task automatic t_backpressure();
    pulse_clr();
    out_ready = 1'b0;
    send(2400, 0, "R2");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R2 held valid", longint'(out_valid), 1);
      check("R2 held value", longint'(out_ppb), -(300 * 128 / 256 + 300 * 32 / 256));
      check("R1 not ready while stalled", longint'(in_ready), 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check("R1 output taken", longint'(out_valid), 0);
    check("R1 ready again", longint'(in_ready), 1);
  endtask

  task automatic t_clear();
    for (int i = 0; i < 5; i++) send(0, 0, "R11");
    pulse_clr();
    check("R11 clear drops lock", longint'(locked), 0);
    check("R11 clear out_valid", longint'(out_valid), 0);
    send(1600, 0, "R11");
    check("R11 fresh start value", longint'(out_ppb), -(100 + 25));
  endtask

  task automatic t_gains();
    pulse_clr();
    set_gains(64, 128);
    send(2048, 0, "R12");
    check("R12 new gains used", longint'(out_ppb), -(64 + 128));
    set_gains(128, 32);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL R1 watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_pi();
    t_average();
    t_interval();
    t_integ_clamp();
    t_saturate();
    t_lock();
    t_backpressure();
    t_clear();
    t_gains();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule